// File: doc/BRIEF.md
# Integer Register File with Result Writeback

This block holds the thirty-two 64-bit integer registers of a processor core together with the writeback stage that formats and filters retiring results before they reach storage. Two operand ports read the file combinationally; a single write port is fed by the writeback logic, which takes one retiring instruction per cycle, along with its class (arithmetic, load, branch-with-link, or no result), its destination, a flag saying whether the result came from a 32-bit operation, and a fault indication.

Results produced by 32-bit operations are turned into canonical 64-bit form by copying bit 31 into the upper half. Every write covers all 64 bits. Register 31 is a hard-wired zero. A destination of 31 is handled per class. A load to 31 becomes a fault-free prefetch hint. A branch-with-link to 31 still redirects and drops only the link write. An arithmetic operation to 31 is discarded along with any fault it raised.

The pipeline drives the read addresses and the retire fields. It consumes the registered event outputs, which report the prefetch strobe and address, an architectural trap, a suppressed trap, and a taken redirect.

Top module: `int_regfile_wb`

## Requirements
- R1: Reset clears registers 0 to 30 to zero. A write performed at a clock edge is returned by either read port in every later cycle until that register is written again.
- R2: Reading register 31 on either port always returns zero, and no retiring instruction ever changes it.
- R3: When ret_long is 1 and the class is arithmetic (ret_class 00) or load (01), the stored value is ret_result[31:0] with bit 31 copied into bits 63:32.
- R4: When ret_long is 0 for an arithmetic or load result, all 64 bits of ret_result are stored unchanged.
- R5: A load (01) with destination 31 writes nothing and, one cycle after it retires, pulses pf_valid for one cycle with pf_addr equal to ret_addr. pf_addr is zero while pf_valid is low. trap_taken stays low; if ret_fault was set, trap_squashed is raised instead.
- R6: A branch-with-link (10) raises redirect one cycle after it retires, whatever its destination. A destination other than 31 receives ret_pc + 4. A destination of 31 receives nothing.
- R7: An arithmetic instruction (00) with destination 31 writes nothing and never raises trap_taken. If ret_fault was set, trap_squashed is raised one cycle later.
- R8: For any instruction that is not dropped (destination not 31, or class 10 or 11), ret_fault is reported on trap_taken one cycle after it retires, and trap_squashed stays low.
- R9: If a read port addresses the nonzero register being written in the same cycle, it returns the formatted value about to be stored.
- R10: A no-result instruction (11) never writes a register and never raises pf_valid or redirect.
- R11: While ret_valid is 0, no register is written and all event outputs are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr_a | input | 5 | Operand A register index |
| rd_addr_b | input | 5 | Operand B register index |
| rd_data_a | output | 64 | Operand A value (combinational) |
| rd_data_b | output | 64 | Operand B value (combinational) |
| ret_valid | input | 1 | A retiring instruction is present |
| ret_class | input | 2 | 00 arithmetic, 01 load, 10 branch-with-link, 11 no result |
| ret_dest | input | 5 | Destination register index |
| ret_long | input | 1 | Result came from a 32-bit operation |
| ret_fault | input | 1 | The instruction raised a fault |
| ret_result | input | 64 | Arithmetic result or loaded data |
| ret_pc | input | 64 | Address of the retiring instruction |
| ret_addr | input | 64 | Effective address of a load |
| pf_valid | output | 1 | Prefetch hint strobe |
| pf_addr | output | 64 | Prefetch hint address |
| trap_taken | output | 1 | Fault reported to the core |
| trap_squashed | output | 1 | Fault suppressed because the instruction was dropped |
| redirect | output | 1 | Branch-with-link took effect |

## Verification
Read data is combinational, so operand values and the same-cycle bypass are due in the cycle the addresses and retire fields are driven. The bench samples them one nanosecond after driving, before the next rising edge. A register write lands at the next rising edge, and the four event outputs are registered once, so they are due in the cycle after the retire. The driver pushes one expected event record per driven cycle, and the monitor pops it just after the following rising edge. Every retirement is therefore matched to exactly one edge.

// File: rtl/rfwb_pkg.sv
package rfwb_pkg;

  localparam int RF_XLEN   = 64;
  localparam int RF_HALF   = RF_XLEN / 2;
  localparam int RF_INSN_B = 4;

  typedef enum logic [1:0] {
    RC_ALU   = 2'b00,
    RC_LOAD  = 2'b01,
    RC_LINK  = 2'b10,
    RC_NORES = 2'b11
  } ret_class_e;

  typedef struct packed {
    logic pf;
    logic trap;
    logic squash;
    logic redir;
  } wb_evt_t;

  // Canonical form of a 32-bit result: upper half copies bit 31.
  function automatic logic [RF_XLEN-1:0] canon_long(input logic [RF_XLEN-1:0] v);
    logic [RF_XLEN-1:0] r;
    r = v;
    for (int i = RF_HALF; i < RF_XLEN; i++) r[i] = v[RF_HALF-1];
    return r;
  endfunction

  function automatic logic [RF_XLEN-1:0] fmt_result(input logic [RF_XLEN-1:0] v,
                                                    input logic is_long);
    return is_long ? canon_long(v) : v;
  endfunction

  // Link value: address of the next sequential instruction word.
  function automatic logic [RF_XLEN-1:0] link_addr(input logic [RF_XLEN-1:0] pc);
    return pc + RF_XLEN'(RF_INSN_B);
  endfunction

endpackage

// File: rtl/rf_wb_format.sv
module rf_wb_format
  import rfwb_pkg::*;
#(
  parameter int XLEN = RF_XLEN,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            valid,
  input  logic [1:0]      cls,
  input  logic [AW-1:0]   dest,
  input  logic            is_long,
  input  logic            fault,
  input  logic [XLEN-1:0] result,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] addr,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [XLEN-1:0] wr_data,
  output wb_evt_t         evt,
  output logic [XLEN-1:0] evt_pf_addr
);

  localparam logic [AW-1:0] ZERO_IDX = AW'(NREG - 1);

  ret_class_e c;
  logic       zero_dst;

  assign c        = ret_class_e'(cls);
  assign zero_dst = (dest == ZERO_IDX);
  assign wr_addr  = dest;

  always_comb begin
    wr_en       = 1'b0;
    wr_data     = '0;
    evt         = '0;
    evt_pf_addr = '0;
    if (valid) begin
      unique case (c)
        RC_ALU: begin
          if (zero_dst) begin
            evt.squash = fault;
          end else begin
            wr_en    = 1'b1;
            wr_data  = fmt_result(result, is_long);
            evt.trap = fault;
          end
        end
        RC_LOAD: begin
          if (zero_dst) begin
            evt.pf      = 1'b1;
            evt.squash  = fault;
            evt_pf_addr = addr;
          end else begin
            wr_en    = 1'b1;
            wr_data  = fmt_result(result, is_long);
            evt.trap = fault;
          end
        end
        RC_LINK: begin
          evt.redir = 1'b1;
          evt.trap  = fault;
          wr_en     = !zero_dst;
          wr_data   = link_addr(pc);
        end
        RC_NORES: begin
          evt.trap = fault;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  parameter int NRD  = 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [XLEN-1:0]     wdata,
  input  logic [NRD*AW-1:0]   raddr,
  output logic [NRD*XLEN-1:0] rdata
);

  localparam int ZERO_IDX = NREG - 1;

  logic [XLEN-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    if (g == ZERO_IDX) begin : g_zero
      assign mem[g] = '0;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)                      mem[g] <= '0;
        else if (we && waddr == AW'(g))  mem[g] <= wdata;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [AW-1:0] a;
    assign a = raddr[p*AW +: AW];
    always_comb begin
      if (a == AW'(ZERO_IDX))       rdata[p*XLEN +: XLEN] = '0;
      else if (we && waddr == a)    rdata[p*XLEN +: XLEN] = wdata;
      else                          rdata[p*XLEN +: XLEN] = mem[a];
    end
  end

endmodule

// File: rtl/rf_event_reg.sv
module rf_event_reg
  import rfwb_pkg::*;
#(
  parameter int XLEN = RF_XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  wb_evt_t         evt_d,
  input  logic [XLEN-1:0] pf_addr_d,
  output wb_evt_t         evt_q,
  output logic [XLEN-1:0] pf_addr_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q     <= '0;
      pf_addr_q <= '0;
    end else begin
      evt_q     <= evt_d;
      pf_addr_q <= evt_d.pf ? pf_addr_d : '0;
    end
  end

endmodule

// File: rtl/int_regfile_wb.sv
module int_regfile_wb
  import rfwb_pkg::*;
#(
  parameter int XLEN = RF_XLEN,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG),
  localparam int NRD = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rd_addr_a,
  input  logic [AW-1:0]   rd_addr_b,
  output logic [XLEN-1:0] rd_data_a,
  output logic [XLEN-1:0] rd_data_b,
  input  logic            ret_valid,
  input  logic [1:0]      ret_class,
  input  logic [AW-1:0]   ret_dest,
  input  logic            ret_long,
  input  logic            ret_fault,
  input  logic [XLEN-1:0] ret_result,
  input  logic [XLEN-1:0] ret_pc,
  input  logic [XLEN-1:0] ret_addr,
  output logic            pf_valid,
  output logic [XLEN-1:0] pf_addr,
  output logic            trap_taken,
  output logic            trap_squashed,
  output logic            redirect
);

  // Named internal events, visible to the bound checker.
  logic            wb_wr_en;
  logic [AW-1:0]   wb_wr_addr;
  logic [XLEN-1:0] wb_wr_data;
  wb_evt_t         wb_evt;
  logic [XLEN-1:0] wb_pf_addr;
  wb_evt_t         evt_q;

  rf_wb_format #(.XLEN(XLEN), .NREG(NREG)) u_fmt (
    .valid       (ret_valid),
    .cls         (ret_class),
    .dest        (ret_dest),
    .is_long     (ret_long),
    .fault       (ret_fault),
    .result      (ret_result),
    .pc          (ret_pc),
    .addr        (ret_addr),
    .wr_en       (wb_wr_en),
    .wr_addr     (wb_wr_addr),
    .wr_data     (wb_wr_data),
    .evt         (wb_evt),
    .evt_pf_addr (wb_pf_addr)
  );

  rf_storage #(.XLEN(XLEN), .NREG(NREG), .NRD(NRD)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wb_wr_en),
    .waddr (wb_wr_addr),
    .wdata (wb_wr_data),
    .raddr ({rd_addr_b, rd_addr_a}),
    .rdata ({rd_data_b, rd_data_a})
  );

  rf_event_reg #(.XLEN(XLEN)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_d     (wb_evt),
    .pf_addr_d (wb_pf_addr),
    .evt_q     (evt_q),
    .pf_addr_q (pf_addr)
  );

  assign pf_valid      = evt_q.pf;
  assign trap_taken    = evt_q.trap;
  assign trap_squashed = evt_q.squash;
  assign redirect      = evt_q.redir;

endmodule

// File: rtl/int_regfile_wb_chk.sv
module int_regfile_wb_chk #(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   rd_addr_a,
  input logic [AW-1:0]   rd_addr_b,
  input logic [XLEN-1:0] rd_data_a,
  input logic [XLEN-1:0] rd_data_b,
  input logic            ret_valid,
  input logic [1:0]      ret_class,
  input logic [AW-1:0]   ret_dest,
  input logic            ret_fault,
  input logic [XLEN-1:0] ret_addr,
  input logic            pf_valid,
  input logic [XLEN-1:0] pf_addr,
  input logic            trap_taken,
  input logic            trap_squashed,
  input logic            redirect,
  input logic            wb_wr_en,
  input logic [AW-1:0]   wb_wr_addr,
  input logic [XLEN-1:0] wb_wr_data
);

  localparam logic [AW-1:0] ZIDX = AW'(NREG - 1);

  AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_a == ZIDX |-> rd_data_a == '0);                                        // R2
  AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_b == ZIDX |-> rd_data_b == '0);                                        // R2
  AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_wr_en |-> wb_wr_addr != ZIDX);                                              // R2
  AST_PREFETCH_HINT: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_class == 2'b01 && ret_dest == ZIDX)
      |=> (pf_valid && pf_addr == $past(ret_addr) && !trap_taken));                // R5
  AST_LINK_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_class == 2'b10) |=> redirect);                               // R6
  AST_ALU_ZERO_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_class == 2'b00 && ret_dest == ZIDX)
      |=> (!trap_taken && trap_squashed == $past(ret_fault)));                     // R7
  AST_TRAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_taken, trap_squashed}));                                        // R8
  AST_BYPASS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_wr_en && rd_addr_a == wb_wr_addr) |-> rd_data_a == wb_wr_data);            // R9
  AST_NORES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_class == 2'b11) |-> !wb_wr_en);                              // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> !(pf_valid || trap_taken || trap_squashed || redirect));        // R11

endmodule

bind int_regfile_wb int_regfile_wb_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd_addr_a     (rd_addr_a),
  .rd_addr_b     (rd_addr_b),
  .rd_data_a     (rd_data_a),
  .rd_data_b     (rd_data_b),
  .ret_valid     (ret_valid),
  .ret_class     (ret_class),
  .ret_dest      (ret_dest),
  .ret_fault     (ret_fault),
  .ret_addr      (ret_addr),
  .pf_valid      (pf_valid),
  .pf_addr       (pf_addr),
  .trap_taken    (trap_taken),
  .trap_squashed (trap_squashed),
  .redirect      (redirect),
  .wb_wr_en      (wb_wr_en),
  .wb_wr_addr    (wb_wr_addr),
  .wb_wr_data    (wb_wr_data)
);

// File: tb/int_regfile_wb_tb.sv
`timescale 1ns/1ps
module int_regfile_wb_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0;
  logic [63:0] rd_data_a, rd_data_b;
  logic        ret_valid = 1'b0;
  logic [1:0]  ret_class = '0;
  logic [4:0]  ret_dest = '0;
  logic        ret_long = 1'b0, ret_fault = 1'b0;
  logic [63:0] ret_result = '0, ret_pc = '0, ret_addr = '0;
  logic        pf_valid, trap_taken, trap_squashed, redirect;
  logic [63:0] pf_addr;

  always #2 clk = ~clk;

  int_regfile_wb u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .ret_valid(ret_valid), .ret_class(ret_class), .ret_dest(ret_dest),
    .ret_long(ret_long), .ret_fault(ret_fault), .ret_result(ret_result),
    .ret_pc(ret_pc), .ret_addr(ret_addr),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .trap_taken(trap_taken),
    .trap_squashed(trap_squashed), .redirect(redirect)
  );

  typedef struct {
    string       tag;
    logic        pf;
    logic [63:0] paddr;
    logic        trap;
    logic        squash;
    logic        redir;
  } exp_t;

  exp_t        sb[$];
  logic [63:0] refm [32];
  int          checks = 0;
  int          failures = 0;
  bit          done = 0;

  function automatic logic [63:0] sext32(input logic [63:0] x);
    return 64'(signed'(x[31:0]));
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus, checks reads, queues the event.
  task automatic step(input string tag, input logic v, input logic [1:0] c,
                      input logic [4:0] d, input logic lg, input logic f,
                      input logic [63:0] res, input logic [63:0] pc,
                      input logic [63:0] adr, input logic [4:0] ra,
                      input logic [4:0] rb);
    logic        ew;
    logic [63:0] ed, ea, eb;
    exp_t        e;
    @(negedge clk);
    ret_valid = v; ret_class = c; ret_dest = d; ret_long = lg; ret_fault = f;
    ret_result = res; ret_pc = pc; ret_addr = adr;
    rd_addr_a = ra; rd_addr_b = rb;
    ew = 1'b0; ed = '0;
    e.tag = tag; e.pf = 0; e.paddr = '0; e.trap = 0; e.squash = 0; e.redir = 0;
    if (v) begin
      case (c)
        2'b00, 2'b01: begin
          if (d == 5'd31) begin
            e.squash = f;
            if (c == 2'b01) begin e.pf = 1; e.paddr = adr; end
          end else begin
            ew = 1; ed = lg ? sext32(res) : res; e.trap = f;
          end
        end
        2'b10: begin
          e.redir = 1; e.trap = f;
          if (d != 5'd31) begin ew = 1; ed = pc + 64'd4; end
        end
        default: e.trap = f;
      endcase
    end
    ea = (ra == 5'd31) ? '0 : (ew && d == ra) ? ed : refm[ra];
    eb = (rb == 5'd31) ? '0 : (ew && d == rb) ? ed : refm[rb];
    #1;
    chk(tag, "rd_data_a", rd_data_a, ea);
    chk(tag, "rd_data_b", rd_data_b, eb);
    if (ew) refm[d] = ed;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag, input logic [4:0] ra, input logic [4:0] rb);
    step(tag, 0, 2'b00, 5'd1, 0, 1, 64'hdead_beef_0000_1111, 64'h40, 64'h80, ra, rb);
  endtask

  // Monitor: every queued record is due just after the next rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "pf_valid", 64'(pf_valid), 64'(e.pf));
        chk(e.tag, "pf_addr", pf_addr, e.paddr);
        chk(e.tag, "trap_taken", 64'(trap_taken), 64'(e.trap));
        chk(e.tag, "trap_squashed", 64'(trap_squashed), 64'(e.squash));
        chk(e.tag, "redirect", 64'(redirect), 64'(e.redir));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) refm[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of every register
    for (int r = 0; r < 32; r++) idle("R1", 5'(r), 5'(31 - r));
    // R4, R1: full-width writes, read back later
    for (int r = 1; r < 31; r++)
      step("R4", 1, 2'b00, 5'(r), 0, 0, {32'(r) * 32'h0101_0101, 32'hf000_0000 | 32'(r)},
           64'h0, 64'h0, 5'(r - 1), 5'd31);
    for (int r = 0; r < 32; r++) idle("R1", 5'(r), 5'(r ^ 5'h1f));
    // R3: longword results, both signs, from arithmetic and load
    step("R3", 1, 2'b00, 5'd4, 1, 0, 64'h1234_5678_8000_0001, 0, 0, 5'd4, 5'd3);
    step("R3", 1, 2'b00, 5'd5, 1, 0, 64'hffff_ffff_7fff_fffe, 0, 0, 5'd4, 5'd5);
    step("R3", 1, 2'b01, 5'd6, 1, 0, 64'h0000_0000_c00e_a124, 0, 64'h1000, 5'd6, 5'd5);
    step("R4", 1, 2'b01, 5'd7, 0, 0, 64'h8000_0000_0000_0007, 0, 64'h1008, 5'd7, 5'd6);
    // R9: same-cycle bypass on both ports
    step("R9", 1, 2'b00, 5'd8, 0, 0, 64'hcafe_f00d_0000_0008, 0, 0, 5'd8, 5'd8);
    idle("R9", 5'd8, 5'd4);
    // R7, R2: arithmetic to register 31, with and without fault
    step("R7", 1, 2'b00, 5'd31, 0, 1, 64'h5555, 0, 0, 5'd31, 5'd31);
    step("R7", 1, 2'b00, 5'd31, 1, 0, 64'hffff_ffff, 0, 0, 5'd31, 5'd8);
    idle("R2", 5'd31, 5'd31);
    // R5: phantom loads become prefetch hints
    step("R5", 1, 2'b01, 5'd31, 0, 1, 64'h77, 0, 64'h0000_7ffd_e000_0040, 5'd31, 5'd7);
    step("R5", 1, 2'b01, 5'd31, 1, 0, 64'h77, 0, 64'h0006_f9e0_0000_0000, 5'd31, 5'd6);
    idle("R5", 5'd31, 5'd5);
    // R6: branch-with-link, real and discarded link
    step("R6", 1, 2'b10, 5'd26, 1, 0, 64'h0, 64'h0000_0000_77f6_3bf4, 0, 5'd26, 5'd25);
    step("R6", 1, 2'b10, 5'd31, 0, 0, 64'h0, 64'h0000_0000_77f4_df08, 0, 5'd31, 5'd26);
    step("R6", 1, 2'b10, 5'd9, 0, 1, 64'h0, 64'hffff_ffff_ffff_fffc, 0, 5'd9, 5'd31);
    // R8: fault on a kept instruction
    step("R8", 1, 2'b00, 5'd3, 0, 1, 64'h3333, 0, 0, 5'd3, 5'd2);
    step("R8", 1, 2'b01, 5'd2, 1, 1, 64'h0000_0000_ffff_fff0, 0, 64'h20, 5'd2, 5'd3);
    // R10: no-result class leaves the destination unchanged
    step("R10", 1, 2'b11, 5'd7, 0, 1, 64'h1111_2222, 64'h100, 0, 5'd7, 5'd7);
    step("R10", 1, 2'b11, 5'd12, 1, 0, 64'h9999, 64'h104, 0, 5'd12, 5'd11);
    idle("R10", 5'd7, 5'd12);
    // R11: valid low with live-looking fields
    step("R11", 0, 2'b10, 5'd13, 0, 1, 64'h4444, 64'h200, 64'h300, 5'd13, 5'd14);
    step("R11", 0, 2'b01, 5'd31, 0, 1, 64'h4444, 64'h200, 64'h300, 5'd13, 5'd31);
    idle("R11", 5'd13, 5'd14);
    // R1: final sweep against the reference array
    for (int r = 0; r < 32; r++) idle("R1", 5'(r), 5'((r + 7) % 32));
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule